// File: doc/BRIEF.md
# Integer to Binary64 Converter

This unit turns a 64-bit general-register value into a binary64 floating-point result. The source can be a signed or unsigned integer of 32 or 64 bits. A precision select chooses between two paths. One rounds the value straight to double precision. The other rounds it once to binary32 and re-expands that value into the binary64 layout, so a single-precision result can be written to a double-width register.

Alongside the result the unit produces a 5-bit class code and rounding status. Rounding follows a 2-bit mode input. The unit also signals whether the status register should be written at all. A 32-bit integer converted to double is always exact, so that case leaves the status untouched. The datapath takes the magnitude, counts its leading zeros, normalises it, and rounds it in two rounders of fixed precision that run in parallel. One register stage sits at the output.

Top module: `icvt_top`

## Requirements
- R1: The type select is encoded as 0 = signed 32-bit, 1 = unsigned 32-bit, 2 = signed 64-bit and 3 = unsigned 64-bit. For the 32-bit types only operand bits 31:0 are used, and the upper 32 bits have no effect on any output.
- R2: In double mode with a 32-bit type the result is the exact value. All status flags are 0 and `status_wr` is 0.
- R3: In double mode with a 64-bit type the value is rounded to a 53-bit significand. The rounding-mode encoding is 00 = nearest-even, 01 = toward zero, 10 = toward +infinity and 11 = toward -infinity.
- R4: In single mode (`to_single` = 1) the value is rounded under the same mode encoding to a 24-bit significand and given in binary64 layout, so result bits 28:0 are 0.
- R5: `flag_inexact` is 1 when rounding changed the value. `flag_frac_inexact` equals it. `exc_summary` is 1 in that cycle whenever `flag_inexact` and `status_wr` are both 1, and it is 0 in any cycle without a new result.
- R6: `flag_rounded_up` is 1 when the magnitude was incremented during rounding. It is never 1 without `flag_inexact`.
- R7: The class code is 5'b00010 for +0, 5'b00100 for a positive nonzero result and 5'b01000 for a negative result. It is taken from the rounded value, and result bit 63 is 1 exactly when the code is 5'b01000.
- R8: A zero integer gives +0.0 (all bits 0) with all flags 0.
- R9: A request with `in_valid` high produces its outputs and `out_valid` on the clock edge that samples it. `out_valid` is 0 one cycle after a cycle without a request. After reset all outputs are 0.
- R10: `status_wr` is 1 for every conversion except a 32-bit source in double mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Conversion request |
| operand | input | 64 | Integer source value |
| int_type | input | 2 | Source integer type select |
| to_single | input | 1 | 1 = round to binary32, then widen |
| rnd_mode | input | 2 | Rounding mode |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Binary64 result |
| res_class | output | 5 | Result class code |
| status_wr | output | 1 | Status register should be updated |
| flag_inexact | output | 1 | Rounding changed the value |
| flag_rounded_up | output | 1 | Magnitude was incremented |
| flag_frac_inexact | output | 1 | Fraction inexact, equal to inexact |
| exc_summary | output | 1 | Exception-summary pulse |

## Verification
Every result, class code and flag is due one cycle after its request. It is registered on the rising edge that samples `in_valid`. The bench drives each request at a falling edge and compares all outputs at the next falling edge. The falling edge after that, with `in_valid` already low, it checks that `out_valid` and the `exc_summary` pulse have dropped. Expected values come from an integer-arithmetic rounding model and, for signed types rounded to nearest in double mode, from a conversion to real.

// File: rtl/icvt_pkg.sv
package icvt_pkg;

   typedef enum logic [1:0] {
      IT_S32 = 2'd0,
      IT_U32 = 2'd1,
      IT_S64 = 2'd2,
      IT_U64 = 2'd3
   } int_type_e;

   typedef enum logic [1:0] {
      RM_NEAR = 2'd0,
      RM_ZERO = 2'd1,
      RM_POS  = 2'd2,
      RM_NEG  = 2'd3
   } rnd_mode_e;

   localparam logic [4:0] CLS_POS_ZERO = 5'b00010;
   localparam logic [4:0] CLS_POS_NORM = 5'b00100;
   localparam logic [4:0] CLS_NEG_NORM = 5'b01000;

   typedef struct packed {
      logic inexact;
      logic rounded_up;
   } rnd_flags_t;

endpackage

// File: rtl/icvt_operand.sv
module icvt_operand #(
   parameter int XLEN   = 64,
   parameter int NARROW = 32
) (
   input  logic [XLEN-1:0] op,
   input  logic [1:0]      int_type,
   output logic            neg,
   output logic [XLEN-1:0] mag,
   output logic            is_zero
);
   localparam int HI = XLEN - NARROW;

   generate
      if (NARROW < 2 || NARROW >= XLEN) begin : g_bad_narrow
         $error("icvt_operand: NARROW must be in 2..XLEN-1");
      end
   endgenerate

   logic            wide, signed_src;
   logic [XLEN-1:0] src;

   always_comb begin
      wide       = int_type[1];
      signed_src = ~int_type[0];
      if (wide) begin
         src = op;
      end else if (signed_src) begin
         src = {{HI{op[NARROW-1]}}, op[NARROW-1:0]};
      end else begin
         src = {{HI{1'b0}}, op[NARROW-1:0]};
      end
      neg     = signed_src & src[XLEN-1];
      mag     = neg ? (~src + 1'b1) : src;
      is_zero = (src == '0);
   end

endmodule

// File: rtl/icvt_lzc.sv
module icvt_lzc #(
   parameter int W  = 64,
   parameter int CW = $clog2(W)
) (
   input  logic [W-1:0]  din,
   output logic [CW-1:0] cnt
);
   generate
      if ((1 << CW) != W) begin : g_bad_width
         $error("icvt_lzc: W must be a power of two");
      end
   endgenerate

   always_comb begin
      cnt = '0;
      for (int i = 0; i < W; i++) begin
         if (din[i]) cnt = CW'(W - 1 - i);
      end
   end

endmodule

// File: rtl/icvt_round.sv
module icvt_round #(
   parameter int W = 64,
   parameter int P = 53
) (
   input  logic [W-1:0] norm,
   input  logic         neg,
   input  logic [1:0]   rm,
   output logic [P-1:0] sig,
   output logic         carry,
   output logic         inexact,
   output logic         rounded_up
);
   import icvt_pkg::*;

   generate
      if (P < 2 || P > W - 2) begin : g_bad_prec
         $error("icvt_round: P must be in 2..W-2");
      end
   endgenerate

   logic [P-1:0] keep;
   logic         guard, sticky, inc;
   logic [P:0]   sum;

   always_comb begin
      keep   = norm[W-1 -: P];
      guard  = norm[W-1-P];
      sticky = |norm[W-2-P:0];
      case (rm)
         RM_NEAR: inc = guard & (sticky | keep[0]);
         RM_ZERO: inc = 1'b0;
         RM_POS:  inc = ~neg & (guard | sticky);
         default: inc = neg & (guard | sticky);
      endcase
      sum        = {1'b0, keep} + {{P{1'b0}}, inc};
      carry      = sum[P];
      sig        = carry ? sum[P:1] : sum[P-1:0];
      inexact    = guard | sticky;
      rounded_up = inc;
   end

endmodule

// File: rtl/icvt_top.sv
module icvt_top #(
   parameter int XLEN    = 64,
   parameter int NARROW  = 32,
   parameter int DP_FRAC = 52,
   parameter int SP_FRAC = 23,
   parameter int DP_EXP  = 11
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [XLEN-1:0] operand,
   input  logic [1:0]      int_type,
   input  logic            to_single,
   input  logic [1:0]      rnd_mode,
   output logic            out_valid,
   output logic [XLEN-1:0] result,
   output logic [4:0]      res_class,
   output logic            status_wr,
   output logic            flag_inexact,
   output logic            flag_rounded_up,
   output logic            flag_frac_inexact,
   output logic            exc_summary
);
   import icvt_pkg::*;

   localparam int LZW     = $clog2(XLEN);
   localparam int DP_P    = DP_FRAC + 1;
   localparam int SP_P    = SP_FRAC + 1;
   localparam int DP_BIAS = (1 << (DP_EXP - 1)) - 1;
   localparam int PAD     = DP_FRAC - SP_FRAC;

   generate
      if (1 + DP_EXP + DP_FRAC != XLEN) begin : g_bad_layout
         $error("icvt_top: sign + exponent + fraction must fill XLEN");
      end
      if (SP_FRAC >= DP_FRAC) begin : g_bad_prec
         $error("icvt_top: single fraction must be narrower than double");
      end
      if (XLEN > DP_BIAS) begin : g_bad_range
         $error("icvt_top: exponent range too small for XLEN");
      end
   endgenerate

   // magnitude and sign
   logic            neg, is_zero;
   logic [XLEN-1:0] mag;

   icvt_operand #(.XLEN(XLEN), .NARROW(NARROW)) u_operand (
      .op       (operand),
      .int_type (int_type),
      .neg      (neg),
      .mag      (mag),
      .is_zero  (is_zero)
   );

   // normalisation
   logic [LZW-1:0]  lz;
   logic [XLEN-1:0] norm;
   logic [LZW-1:0]  msb_pos;

   icvt_lzc #(.W(XLEN)) u_lzc (
      .din (mag),
      .cnt (lz)
   );

   assign norm    = mag << lz;
   assign msb_pos = LZW'(XLEN - 1) - lz;

   // one rounder per destination precision; index 0 = double, 1 = single
   logic [DP_P-1:0] rnd_sig   [2];
   logic            rnd_carry [2];
   rnd_flags_t      rnd_flg   [2];

   for (genvar g = 0; g < 2; g++) begin : g_prec
      localparam int GP = (g == 0) ? DP_P : SP_P;
      logic [GP-1:0] sig_g;
      logic          inex_g, up_g;

      icvt_round #(.W(XLEN), .P(GP)) u_round (
         .norm       (norm),
         .neg        (neg),
         .rm         (rnd_mode),
         .sig        (sig_g),
         .carry      (rnd_carry[g]),
         .inexact    (inex_g),
         .rounded_up (up_g)
      );

      assign rnd_sig[g] = DP_P'(sig_g) << (DP_P - GP);
      assign rnd_flg[g] = '{inexact: inex_g, rounded_up: up_g};
   end

   // result assembly
   logic              sel;
   logic [DP_EXP-1:0] exp_b;
   logic [XLEN-1:0]   res_c;
   logic [4:0]        cls_c;
   logic              swr_c, inex_c, up_c;

   always_comb begin
      sel   = to_single;
      exp_b = DP_EXP'(DP_BIAS) + DP_EXP'(msb_pos) + DP_EXP'(rnd_carry[sel]);
      if (is_zero) begin
         res_c  = '0;
         cls_c  = CLS_POS_ZERO;
         inex_c = 1'b0;
         up_c   = 1'b0;
      end else begin
         res_c  = {neg, exp_b, rnd_sig[sel][DP_FRAC-1:0]};
         cls_c  = neg ? CLS_NEG_NORM : CLS_POS_NORM;
         inex_c = rnd_flg[sel].inexact;
         up_c   = rnd_flg[sel].rounded_up;
      end
      swr_c = to_single | int_type[1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid         <= 1'b0;
         result            <= '0;
         res_class         <= '0;
         status_wr         <= 1'b0;
         flag_inexact      <= 1'b0;
         flag_rounded_up   <= 1'b0;
         flag_frac_inexact <= 1'b0;
         exc_summary       <= 1'b0;
      end else begin
         out_valid   <= in_valid;
         exc_summary <= in_valid & inex_c & swr_c;
         if (in_valid) begin
            result            <= res_c;
            res_class         <= cls_c;
            status_wr         <= swr_c;
            flag_inexact      <= inex_c;
            flag_rounded_up   <= up_c;
            flag_frac_inexact <= inex_c;
         end
      end
   end

   // checks next to the logic they guard
   a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && !exc_summary);

   a_r2_exact_narrow: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !status_wr |-> !flag_inexact && !flag_rounded_up && !exc_summary);

   a_r5_summary: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && flag_inexact && status_wr |-> exc_summary);

   a_r6_up_implies_inexact: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && flag_rounded_up |-> flag_inexact);

   a_r7_sign_class: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (result[XLEN-1] == (res_class == CLS_NEG_NORM)));

   a_r8_zero: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && res_class == CLS_POS_ZERO |-> result == '0 && !flag_inexact);

   a_r4_single_pad: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && to_single) |-> result[PAD-1:0] == '0);

   a_r10_status: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> status_wr == ($past(to_single) || $past(int_type[1])));

endmodule

// File: tb/test_icvt_top.sv
module test_icvt_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] operand = '0;
   logic [1:0]  int_type = '0;
   logic        to_single = 1'b0;
   logic [1:0]  rnd_mode = '0;
   logic        out_valid, status_wr, flag_inexact, flag_rounded_up;
   logic        flag_frac_inexact, exc_summary;
   logic [63:0] result;
   logic [4:0]  res_class;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   icvt_top i_icvt_top (
      .clk               (clk),
      .rst_n             (rst_n),
      .in_valid          (in_valid),
      .operand           (operand),
      .int_type          (int_type),
      .to_single         (to_single),
      .rnd_mode          (rnd_mode),
      .out_valid         (out_valid),
      .result            (result),
      .res_class         (res_class),
      .status_wr         (status_wr),
      .flag_inexact      (flag_inexact),
      .flag_rounded_up   (flag_rounded_up),
      .flag_frac_inexact (flag_frac_inexact),
      .exc_summary       (exc_summary)
   );

   // reference built from integer arithmetic on the true value
   function automatic void model(input logic [63:0] op, input logic [1:0] typ,
                                 input bit sgl, input logic [1:0] rm,
                                 output logic [63:0] r, output logic [4:0] cls,
                                 output bit inex, output bit up, output bit sw);
      logic [63:0] src;
      bit          neg;
      logic [64:0] m, q, rem, half, t;
      int          msb, p, s;
      bit          inc;
      case (typ)
         2'd0: begin src = {{32{op[31]}}, op[31:0]}; neg = op[31]; end
         2'd1: begin src = {32'd0, op[31:0]};        neg = 1'b0;   end
         2'd2: begin src = op;                       neg = op[63]; end
         default: begin src = op;                    neg = 1'b0;   end
      endcase
      m    = neg ? (65'd0 - {src[63], src}) : {1'b0, src};
      sw   = sgl || typ[1];
      inex = 1'b0;
      up   = 1'b0;
      if (m == 0) begin
         r   = '0;
         cls = 5'b00010;
         return;
      end
      msb = 0;
      for (int i = 0; i < 65; i++) if (m[i]) msb = i;
      p = sgl ? 24 : 53;
      if (msb + 1 > p) begin
         s    = msb + 1 - p;
         q    = m >> s;
         rem  = m - (q << s);
         half = 65'd1 << (s - 1);
         case (rm)
            2'd0: inc = (rem > half) || (rem == half && q[0]);
            2'd1: inc = 1'b0;
            2'd2: inc = !neg && rem != 0;
            default: inc = neg && rem != 0;
         endcase
         inex = rem != 0;
         up   = inc;
         m    = (q + 65'(inc)) << s;
         for (int i = 0; i < 65; i++) if (m[i]) msb = i;
      end
      t   = m << (64 - msb);
      r   = {neg, 11'(1023 + msb), t[63:12]};
      cls = neg ? 5'b01000 : 5'b00100;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [63:0] op, input logic [1:0] typ,
                        input bit sgl, input logic [1:0] rm, input string req);
      logic [63:0] er;
      logic [4:0]  ec;
      bit          ei, eu, es;
      model(op, typ, sgl, rm, er, ec, ei, eu, es);
      @(negedge clk);
      operand = op; int_type = typ; to_single = sgl; rnd_mode = rm;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid == 1'b1, "R9", "out_valid", 64'(out_valid), 64'd1);
      check(result == er, req, "result", result, er);
      check(res_class == ec, "R7", "class", 64'(res_class), 64'(ec));
      check(status_wr == es, "R10", "status_wr", 64'(status_wr), 64'(es));
      check(flag_inexact == ei, "R5", "inexact", 64'(flag_inexact), 64'(ei));
      check(flag_frac_inexact == ei, "R5", "frac_inexact",
            64'(flag_frac_inexact), 64'(ei));
      check(exc_summary == (ei && es), "R5", "exc_summary",
            64'(exc_summary), 64'(ei && es));
      check(flag_rounded_up == eu, "R6", "rounded_up",
            64'(flag_rounded_up), 64'(eu));
      if (sgl) check(result[28:0] == '0, "R4", "single pad", result, er);
      if (!es) check(!flag_inexact && !flag_rounded_up, "R2", "narrow flags",
                     64'({flag_inexact, flag_rounded_up}), 64'd0);
      if (op == 0 || (typ[1] == 1'b0 && op[31:0] == 0))
         check(result == 0 && !flag_inexact, "R8", "zero", result, 64'd0);
      @(negedge clk);
      check(!out_valid && !exc_summary, "R9", "idle drop",
            64'({out_valid, exc_summary}), 64'd0);
   endtask

   initial begin
      logic [63:0] corners [10];
      corners[0] = 64'd0;
      corners[1] = 64'hFFFF_FFFF_FFFF_FFFF;
      corners[2] = 64'h8000_0000_0000_0000;
      corners[3] = 64'h7FFF_FFFF_FFFF_FFFF;
      corners[4] = 64'h0000_0000_8000_0000;
      corners[5] = 64'h0000_0000_7FFF_FFFF;
      corners[6] = 64'h0020_0000_0000_0001;   // tie for double
      corners[7] = 64'h0020_0000_0000_0003;
      corners[8] = 64'h0000_0000_0100_0001;   // tie for single
      corners[9] = 64'hDEAD_BEEF_0123_4567;

      repeat (3) @(negedge clk);
      check(!out_valid && result == 0 && res_class == 0 && !exc_summary,
            "R9", "reset state", result, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: upper half ignored for 32-bit types
      apply(64'hDEAD_BEEF_0000_0005, 2'd0, 1'b0, 2'd0, "R1");
      check(result == 64'h4014_0000_0000_0000, "R1", "upper ignored s32",
            result, 64'h4014_0000_0000_0000);
      apply(64'h1234_5678_FFFF_FFFF, 2'd1, 1'b0, 2'd1, "R1");
      check(result == 64'h41EF_FFFF_FFE0_0000, "R1", "upper ignored u32",
            result, 64'h41EF_FFFF_FFE0_0000);
      // R2: -1 as s32 to double is exact
      apply(64'h0000_0000_FFFF_FFFF, 2'd0, 1'b0, 2'd3, "R2");
      check(result == 64'hBFF0_0000_0000_0000, "R2", "minus one",
            result, 64'hBFF0_0000_0000_0000);

      // R3 R4: corners across every type, precision and rounding mode
      for (int c = 0; c < 10; c++)
         for (int ty = 0; ty < 4; ty++)
            for (int sg = 0; sg < 2; sg++)
               for (int rmi = 0; rmi < 4; rmi++)
                  apply(corners[c], 2'(ty), sg[0], 2'(rmi), sg ? "R4" : "R3");

      // constrained random
      void'($urandom(32'h5EED_1234));
      for (int k = 0; k < 2000; k++) begin
         logic [63:0] op;
         int          shape;
         shape = $urandom_range(0, 3);
         op = {$urandom(), $urandom()};
         if (shape == 1) op = op >> $urandom_range(0, 63);
         if (shape == 2) op = ~(op >> $urandom_range(0, 63));
         if (shape == 3) op = 64'd1 << $urandom_range(0, 63);
         apply(op, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
               2'($urandom_range(0, 3)), "R3");
         // R3: cross-check against real conversion, nearest-even
         if (int_type == 2'd2 && !to_single && rnd_mode == 2'd0) begin
            real rv;
            rv = real'($signed(op));
            check(result == $realtobits(rv), "R3", "real ref",
                  result, $realtobits(rv));
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R9 watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

endmodule